// File: doc/BRIEF.md
# 64-bit Pseudo-Carry Prefix Adder

This block adds two 64-bit operands and a carry-in, producing a 64-bit sum and a carry-out. Inside, it does not pass true carries. It passes Ling-style pseudo-carries `H`. The recurrence is `H_i = g_i | (p_(i-1) & H_(i-1))`, where `g = a & b` and `p = a | b`. Each true carry is recovered only at the end, as `c_i = p_(i-1) & H_(i-1)`. Each sum bit is then the half-sum `a ^ b` XORed with that carry.

The operand is split into 16-bit groups. Each group runs its own prefix network. A second-level network merges the group totals, and every group then folds in the pseudo-carry from the group below it. A build parameter selects the cell type inside the networks:
- Pure two-input cells, arranged as a divide-and-conquer tree.
- Mixed cells of two, three and four inputs, arranged as a base-4 tree. This halves the number of levels.

The result is captured in one output register stage, loaded when the input valid flag is high.

Top module: `ling_add64`

## Requirements
- R1: One cycle after a clock edge where `in_vld` is 1, `sum` equals `(a + b + cin) mod 2^64`.
- R2: One cycle after an accepted operation, `cout` equals bit 64 of the 65-bit value `a + b + cin`. For example, all-ones plus all-ones gives `sum` = all-ones minus one and `cout` = 1.
- R3: `cin` adds exactly one at bit position 0. All-ones plus zero with `cin` = 1 gives `sum` = 0 and `cout` = 1.
- R4: A carry born at bit 0 ripples through all 64 positions. All-ones plus one gives `sum` = 0 and `cout` = 1.
- R5: A carry crosses each 16-bit group boundary. Examples:
  - Low 16 bits all ones, plus one, gives bit 16 set.
  - Low 48 bits all ones, plus one, gives bit 48 set.
  - Alternating patterns `0xAAAA...` plus `0x5555...` give all ones.
- R6: The two settings of the `MIXED` parameter (0 = two-input cells only, 1 = mixed two/three/four-input cells) produce bit-identical `sum` and `cout` for every input.
- R7: `out_vld` is 1 exactly in the cycle after a clock edge where `in_vld` was 1, and 0 otherwise.
- R8: While `in_vld` is 0, `sum` and `cout` keep their last values.
- R9: While `rst_n` is 0, `out_vld`, `sum` and `cout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Load enable for the output register |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| out_vld | output | 1 | Registered result is new this cycle |
| sum | output | 64 | Registered sum |
| cout | output | 1 | Registered carry out of bit 63 |

## Verification
The bench builds two copies side by side. One copy uses `MIXED` = 1, so its 16-bit groups use base-4 trees and its second level is a single four-input cell. The other copy uses `MIXED` = 0, so its groups use two-input trees of four levels and its second level has two levels.

Running both copies on the same operands exposes any fault that appears in only one cell arrangement. The directed patterns drive carries that cross every group boundary, the bit-0 seed and the carry-in. Ten thousand random operand pairs fill in the rest.

// File: rtl/ling_pkg.sv
package ling_pkg;

  // Generate/propagate pair carried through the pseudo-carry prefix networks.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine an upper span with the adjacent lower span.
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/ling_leaf.sv
module ling_leaf
  import ling_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output gp_t  [W-1:0] leaf,
  output logic [W-1:0] prop,
  output logic [W-1:0] half
);

  // Leaf i holds g_i together with the propagate of the bit below (p_(i-1)).
  // The carry-in is folded into the generate of bit 0.
  always_comb begin
    prop = a | b;
    half = a ^ b;
    for (int i = 0; i < W; i++) begin
      leaf[i].g = a[i] & b[i];
      leaf[i].p = (i == 0) ? 1'b1 : prop[i-1];
    end
    leaf[0].g = (a[0] & b[0]) | cin;
  end

endmodule

// File: rtl/ling_prefix.sv
module ling_prefix
  import ling_pkg::*;
#(
  parameter int W     = 16,
  parameter bit MIXED = 1'b1
) (
  input  gp_t [W-1:0] din,
  output gp_t [W-1:0] dout
);

  generate
    if (MIXED) begin : g_radix4
      // Base-4 tree. At each level, element k of a quad takes k+1 inputs,
      // so the cells have two, three or four inputs.
      localparam int LV = ($clog2(W) + 1) / 2;
      gp_t [W-1:0] st [0:LV];

      always_comb begin
        st[0] = din;
        for (int l = 0; l < LV; l++) begin
          for (int i = 0; i < W; i++) begin
            int  sub;
            int  k;
            int  base;
            gp_t acc;
            sub  = 1 << (2 * l);
            k    = (i >> (2 * l)) & 3;
            base = (i >> (2 * l + 2)) << (2 * l + 2);
            acc  = st[l][i];
            for (int m = 1; m < 4; m++) begin
              if (m <= k) acc = gp_merge(acc, st[l][base + (k - m + 1) * sub - 1]);
            end
            st[l+1][i] = acc;
          end
        end
        dout = st[LV];
      end
    end else begin : g_radix2
      // Divide-and-conquer tree built from two-input cells only.
      localparam int LV = $clog2(W);
      gp_t [W-1:0] st [0:LV];

      always_comb begin
        st[0] = din;
        for (int l = 0; l < LV; l++) begin
          for (int i = 0; i < W; i++) begin
            if (((i >> l) & 1) == 1)
              st[l+1][i] = gp_merge(st[l][i], st[l][((i >> l) << l) - 1]);
            else
              st[l+1][i] = st[l][i];
          end
        end
        dout = st[LV];
      end
    end
  endgenerate

endmodule

// File: rtl/ling_add64.sv
module ling_add64
  import ling_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int BLK   = 16,
  parameter bit MIXED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic             out_vld,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NBLK = WIDTH / BLK;

  gp_t  [WIDTH-1:0] leaf;
  gp_t  [WIDTH-1:0] loc;
  gp_t  [NBLK-1:0]  tot;
  gp_t  [NBLK-1:0]  tot_pre;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] half;
  logic [WIDTH-1:0] h;
  logic [WIDTH-1:0] carry;
  logic [WIDTH-1:0] sum_d;
  logic             cout_d;

  // Pre-processing: per-bit generate, propagate and half-sum.
  ling_leaf #(.W(WIDTH)) u_leaf (
    .a(a), .b(b), .cin(cin), .leaf(leaf), .prop(prop), .half(half)
  );

  // Level 1: one pseudo-carry prefix network per group.
  genvar gb;
  generate
    for (gb = 0; gb < NBLK; gb++) begin : g_grp
      ling_prefix #(.W(BLK), .MIXED(MIXED)) u_grp (
        .din (leaf[gb*BLK +: BLK]),
        .dout(loc[gb*BLK +: BLK])
      );
      assign tot[gb] = loc[gb*BLK + BLK - 1];
    end
  endgenerate

  // Level 2: merge the group totals.
  ling_prefix #(.W(NBLK), .MIXED(MIXED)) u_top (
    .din (tot),
    .dout(tot_pre)
  );

  // Fold the pseudo-carry of the group below into every bit of a group.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_fold
      if (gi < BLK) begin : g_first
        assign h[gi] = loc[gi].g;
      end else begin : g_rest
        assign h[gi] = loc[gi].g | (loc[gi].p & tot_pre[gi/BLK - 1].g);
      end
    end
  endgenerate

  // Post-processing: the propagate factor is applied only here.
  always_comb begin
    carry[0] = cin;
    for (int i = 1; i < WIDTH; i++) carry[i] = prop[i-1] & h[i-1];
    sum_d  = half ^ carry;
    cout_d = prop[WIDTH-1] & h[WIDTH-1];
  end

  // Output register stage: next-state logic, then the register.
  logic             vld_n;
  logic [WIDTH-1:0] sum_n;
  logic             cout_n;

  always_comb begin
    vld_n  = in_vld;
    sum_n  = sum;
    cout_n = cout;
    if (in_vld) begin
      sum_n  = sum_d;
      cout_n = cout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      sum     <= '0;
      cout    <= 1'b0;
    end else begin
      out_vld <= vld_n;
      sum     <= sum_n;
      cout    <= cout_n;
    end
  end

  // Assertions
  p_sum_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ({cout, sum} == $past({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})));

  p_bit0_cin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (sum[0] == $past(a[0] ^ b[0] ^ cin)));

  p_ripple_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (&a) && (b == '0)) |=> (cout == $past(cin)));

  p_vld_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_vld_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(sum) && $stable(cout)));

endmodule

// File: tb/tb_ling_add64.sv
module tb_ling_add64;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 64;

  logic         clk;
  logic         rst_n;
  logic         in_vld;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cin;
  logic         out_vld;
  logic [W-1:0] sum;
  logic         cout;
  logic         out_vld2;
  logic [W-1:0] sum2;
  logic         cout2;

  int checks;
  int fails;
  bit mon_on;
  bit done;

  logic [W:0] exp_q [$];
  logic       vld_q [$];
  string      tag_q [$];
  logic [W:0] last_exp;

  ling_add64 #(.WIDTH(W), .BLK(16), .MIXED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b), .cin(cin),
    .out_vld(out_vld), .sum(sum), .cout(cout)
  );

  ling_add64 #(.WIDTH(W), .BLK(16), .MIXED(1'b0)) dut_r2 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b), .cin(cin),
    .out_vld(out_vld2), .sum(sum2), .cout(cout2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation (or an idle cycle) and pushes the expectation.
  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc,
                       input logic v, input string tag);
    @(negedge clk);
    a      = xa;
    b      = xb;
    cin    = xc;
    in_vld = v;
    exp_q.push_back({1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc});
    vld_q.push_back(v);
    tag_q.push_back(tag);
    mon_on = 1'b1;
  endtask

  // Monitor: pops one expectation per cycle, just after the edge that registers it.
  always @(posedge clk) begin
    #1;
    if (mon_on && rst_n && exp_q.size() > 0) begin
      logic [W:0] e;
      logic       v;
      string      t;
      e = exp_q.pop_front();
      v = vld_q.pop_front();
      t = tag_q.pop_front();
      check(out_vld == v, "R7 out_vld", {{W{1'b0}}, out_vld}, {{W{1'b0}}, v});
      if (v) begin
        last_exp = e;
        check({cout, sum} == e, t, {cout, sum}, e);
      end else begin
        check({cout, sum} == last_exp, "R8 hold while idle", {cout, sum}, last_exp);
      end
      check({cout2, sum2} == {cout, sum}, "R6 radix settings agree", {cout2, sum2}, {cout, sum});
    end
  end

  initial begin
    checks   = 0;
    fails    = 0;
    mon_on   = 1'b0;
    done     = 1'b0;
    last_exp = '0;
    rst_n    = 1'b0;
    in_vld   = 1'b0;
    a        = '1;
    b        = '1;
    cin      = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check({out_vld, cout, sum} == '0, "R9 reset state", {cout, sum}, '0);
    check({out_vld2, cout2, sum2} == '0, "R9 reset state r2", {cout2, sum2}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    drive('0, '0, 1'b0, 1'b1, "R1 zero plus zero");
    drive(64'd12345, 64'd67890, 1'b0, 1'b1, "R1 small values");
    drive('1, '1, 1'b0, 1'b1, "R2 max plus max");
    drive('1, '1, 1'b1, 1'b1, "R2 max plus max plus cin");
    drive('1, '0, 1'b1, 1'b1, "R3 cin into all ones");
    drive('0, '0, 1'b1, 1'b1, "R3 cin alone");
    drive('1, 64'd1, 1'b0, 1'b1, "R4 full ripple");
    drive(64'h0000_0000_0000_FFFF, 64'd1, 1'b0, 1'b1, "R5 cross boundary 16");
    drive(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b1, "R5 cross boundary 32");
    drive(64'h0000_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1, "R5 cross boundary 48");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b1, "R5 into top bit");
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 1'b1, "R5 alternating");
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, 1'b1, "R5 alternating plus cin");
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b1, "R5 alternating doubled");
    for (int i = 0; i < 3; i++) drive('0, '1, 1'b1, 1'b0, "R8 idle");
    for (int k = 0; k < W; k++) begin
      drive(({W{1'b1}} >> (W - 1 - k)), 64'd1, 1'b0, 1'b1, "R5 walking carry chain");
    end
    for (int i = 0; i < 10000; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [31:0]  rs;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rs = $urandom;
      drive(ra, rb, rs[0], (rs[5:1] != 5'd0), (rs[5:1] != 5'd0) ? "R1 random" : "R8 random idle");
    end
    drive('0, '0, 1'b0, 1'b0, "R8 final idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule